// File: doc/BRIEF.md
# QC-LDPC Base Matrix Shift Expander

This block holds the base (prototype) matrix of a quasi-cyclic LDPC code in an internal table of 24 block columns and up to 12 block rows. On a start strobe it walks the configured rows and emits one descriptor for every sub-block that is not empty. Each descriptor names the block row, the block column and the cyclic shift, rescaled from the 96-wide reference expansion to the expansion factor that the requested codeword length implies.

A decoder or encoder controller loads the table once per code through a simple write port. It then selects the number of block rows for the code rate, the codeword length and the scaling mode, and pulses start. Descriptors leave through a valid/ready stream, so a slow consumer can throttle the walk. A one-cycle done pulse closes each walk. A length or row count that the block cannot serve raises an error flag and produces nothing.

Top module: `qc_shift_walker`

## Requirements
- R1: A codeword length L is accepted when it lies in 576..2304 and is a multiple of 96. The expansion factor is z = L/24. An accepted start clears the error flag, and the walk ends with exactly one done pulse.
- R2: A start with an unsupported length, or with a row count of 0 or above 12, sets the error flag from the next cycle until the next accepted start. Such a start emits no descriptor and no done pulse.
- R3: A table entry with bit 7 set (the value -1 is stored as 8'hFF) is an empty sub-block and produces no descriptor. The number of descriptors equals the number of non-empty entries in the walked rows.
- R4: An entry of 0 produces a descriptor with shift 0 in both modes.
- R5: With the mode input low, a positive entry p (1..95) gives shift floor(p*z/96). This is exact for every supported z, and the shift is always below 96.
- R6: With the mode input high, a positive entry p gives shift p mod z.
- R7: Descriptors come out in row-major order, with the column innermost. They cover rows 0 to cfg_rows-1 only, and each carries the row and column of its entry.
- R8: While desc_valid is high and desc_ready is low, desc_valid stays high and the row, column and shift do not change.
- R9: done is a single-cycle pulse. It comes after the last entry has been walked and the last descriptor has been accepted, and desc_valid is low while done is high.
- R10: The length, row count and mode are captured at an accepted start. While a walk is in progress, start pulses and table writes are ignored.
- R11: After reset, desc_valid, done and len_err are low, and every table entry reads as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe (honoured only when idle) |
| wr_row | input | 4 | Block row of the table write |
| wr_col | input | 5 | Block column of the table write (0..23) |
| wr_data | input | 8 | Entry value: 8'hFF empty, 0..95 shift |
| cfg_rows | input | 4 | Number of block rows to walk (1..12) |
| cfg_len | input | 12 | Codeword length in bits |
| cfg_modulo | input | 1 | 1: modulo scaling, 0: proportional scaling |
| start | input | 1 | Start a walk (honoured only when idle) |
| desc_ready | input | 1 | Consumer accepts the current descriptor |
| desc_valid | output | 1 | Descriptor present |
| desc_row | output | 4 | Block row of the descriptor |
| desc_col | output | 5 | Block column of the descriptor |
| desc_shift | output | 7 | Cyclic shift scaled to z |
| done | output | 1 | One-cycle pulse at the end of a walk |
| len_err | output | 1 | Last start was rejected |

## Verification
The bound checker watches the stream protocol on every cycle. It checks that a descriptor held under back-pressure stays frozen, that shifts and positions stay in range, that done lasts one cycle with no descriptor beside it, and that an error never coincides with output. The values themselves can only be shown by the bench's scenarios. These cover the scaled shifts in both modes across all nineteen lengths, the order and count of descriptors against a model table, skipped empty entries, rejected configurations, and the fact that writes and starts during a walk leave no trace.

// File: rtl/qcx_pkg.sv
// Package: shared constants and types of the QC-LDPC shift expander.
// Assumes a reference expansion factor of 96 and 24 block columns.
package qcx_pkg;
    localparam int QX_COLS     = 24;
    localparam int QX_MAX_ROWS = 12;
    localparam int QX_REF_Z    = 96;
    localparam int QX_MIN_Z    = 24;
    localparam int QX_STEP_Z   = 4;
    localparam int QX_ENT_W    = 8;
    localparam int QX_LEN_W    = 12;
    localparam int QX_ROW_W    = $clog2(QX_MAX_ROWS + 1);
    localparam int QX_COL_W    = $clog2(QX_COLS);
    localparam int QX_SH_W     = $clog2(QX_REF_Z);
    localparam int QX_Z_W      = $clog2(QX_REF_Z + 1);

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_WALK  = 2'd1,
        WK_FLUSH = 2'd2
    } wk_state_t;
endpackage

// File: rtl/qcx_base_store.sv
// Module: register table holding the base matrix entries.
// Does: one write port and one asynchronous read port, reset to all-empty.
// Assumes: out-of-range write addresses are dropped and out-of-range reads return empty.
module qcx_base_store #(
    parameter int ROWS  = 12,
    parameter int COLS  = 24,
    parameter int ENT_W = 8,
    parameter int ROW_W = 4,
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic [ENT_W-1:0] rd_data
);
    logic [ENT_W-1:0] mem [ROWS][COLS];
    logic             wr_in_range;
    logic             rd_in_range;

    // Decide whether the addresses fall inside the table.
    always_comb begin
        wr_in_range = (wr_row < ROW_W'(ROWS)) && (wr_col < COL_W'(COLS));
        rd_in_range = (rd_row < ROW_W'(ROWS)) && (rd_col < COL_W'(COLS));
    end

    // Clear the table on reset, otherwise take one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem[r][c] <= '1;
                end
            end
        end else if (wr_en && wr_in_range) begin
            mem[wr_row][wr_col] <= wr_data;
        end
    end

    // Present the addressed entry, or empty when out of range.
    always_comb begin
        rd_data = '1;
        if (rd_in_range) begin
            rd_data = mem[rd_row][rd_col];
        end
    end
endmodule

// File: rtl/qcx_len_decode.sv
// Module: codeword length check and expansion factor derivation.
// Does: accepts lengths that are a multiple of COLS*STEP_Z inside the
// supported window and returns z = length / COLS.
// Assumes: the caller ignores z whenever ok is low.
module qcx_len_decode #(
    parameter int COLS   = 24,
    parameter int MIN_Z  = 24,
    parameter int MAX_Z  = 96,
    parameter int STEP_Z = 4,
    parameter int LEN_W  = 12,
    parameter int Z_W    = 7
) (
    input  logic [LEN_W-1:0] len,
    output logic             ok,
    output logic [Z_W-1:0]   z
);
    localparam int MIN_LEN  = COLS * MIN_Z;
    localparam int MAX_LEN  = COLS * MAX_Z;
    localparam int STEP_LEN = COLS * STEP_Z;

    // Range and step test on the requested length.
    always_comb begin
        ok = (len >= LEN_W'(MIN_LEN)) && (len <= LEN_W'(MAX_LEN))
             && ((len % LEN_W'(STEP_LEN)) == '0);
    end

    // Expansion factor from the length.
    always_comb begin
        z = Z_W'(len / LEN_W'(COLS));
    end
endmodule

// File: rtl/qcx_shift_scale.sv
// Module: rescales a reference shift to the run-time expansion factor.
// Does: proportional mode gives floor(p*z/REF_Z) through a full product and
// a constant divide. Modulo mode gives p mod z through a short chain of
// conditional subtractions.
// Assumes: p < REF_Z and MIN_Z <= z <= REF_Z, so the chain length
// (REF_Z-1)/MIN_Z is enough to finish the modulo.
module qcx_shift_scale #(
    parameter int REF_Z = 96,
    parameter int MIN_Z = 24,
    parameter int SH_W  = 7,
    parameter int Z_W   = 7
) (
    input  logic [SH_W-1:0] base_val,
    input  logic [Z_W-1:0]  z,
    input  logic            use_mod,
    output logic [SH_W-1:0] shift
);
    localparam int PROD_W = SH_W + Z_W;
    localparam int N_SUB  = (REF_Z - 1) / MIN_Z;
    localparam int REM_W  = (SH_W > Z_W) ? SH_W : Z_W;

    logic [PROD_W-1:0] prod;
    logic [SH_W-1:0]   prop_shift;
    logic [REM_W-1:0]  rem;

    // Proportional path: exact product, then a constant divide.
    always_comb begin
        prod       = PROD_W'(base_val) * PROD_W'(z);
        prop_shift = SH_W'(prod / PROD_W'(REF_Z));
    end

    // Modulo path: subtract z while the remainder is not below it.
    always_comb begin
        rem = REM_W'(base_val);
        for (int i = 0; i < N_SUB; i++) begin
            if (rem >= REM_W'(z)) begin
                rem = rem - REM_W'(z);
            end
        end
    end

    // Pick the mode's result.
    always_comb begin
        shift = use_mod ? SH_W'(rem) : prop_shift;
    end
endmodule

// File: rtl/qc_shift_walker.sv
// Module: top of the QC-LDPC base matrix shift expander.
// Does: stores the base matrix, walks rows 0..cfg_rows-1 in row-major order
// with the column innermost, skips empty entries and streams one descriptor
// (row, column, scaled shift) per non-empty entry. It then pulses done.
// Assumes: stored shifts are 0..95 or empty (bit 7 set). The consumer keeps
// valid/ready semantics, and configuration is sampled only at an accepted start.
module qc_shift_walker
    import qcx_pkg::*;
#(
    parameter int COLS     = QX_COLS,
    parameter int MAX_ROWS = QX_MAX_ROWS,
    parameter int REF_Z    = QX_REF_Z,
    parameter int MIN_Z    = QX_MIN_Z,
    parameter int STEP_Z   = QX_STEP_Z,
    parameter int ENT_W    = QX_ENT_W,
    parameter int LEN_W    = QX_LEN_W,
    parameter int ROW_W    = $clog2(MAX_ROWS + 1),
    parameter int COL_W    = $clog2(COLS),
    parameter int SH_W     = $clog2(REF_Z),
    parameter int Z_W      = $clog2(REF_Z + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [ROW_W-1:0] cfg_rows,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_modulo,
    input  logic             start,
    input  logic             desc_ready,
    output logic             desc_valid,
    output logic [ROW_W-1:0] desc_row,
    output logic [COL_W-1:0] desc_col,
    output logic [SH_W-1:0]  desc_shift,
    output logic             done,
    output logic             len_err
);
    localparam int LAST_COL = COLS - 1;

    wk_state_t        st_q;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] last_row_q;
    logic [COL_W-1:0] col_q;
    logic [Z_W-1:0]   z_q;
    logic             mod_q;
    logic             dv_q;
    logic [ROW_W-1:0] drow_q;
    logic [COL_W-1:0] dcol_q;
    logic [SH_W-1:0]  dsh_q;
    logic             done_q;
    logic             err_q;

    logic             busy;
    logic             store_wr;
    logic [ENT_W-1:0] ent;
    logic             ent_empty;
    logic             len_ok;
    logic [Z_W-1:0]   z_new;
    logic             rows_ok;
    logic             start_ok;
    logic             slot_free;
    logic             at_last_col;
    logic             at_last_row;
    logic [SH_W-1:0]  scaled;

    // Gate writes so the table is frozen during a walk.
    always_comb begin
        busy     = (st_q != WK_IDLE);
        store_wr = wr_en && !busy;
    end

    qcx_base_store #(
        .ROWS  (MAX_ROWS),
        .COLS  (COLS),
        .ENT_W (ENT_W),
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_wr),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_data (wr_data),
        .rd_row  (row_q),
        .rd_col  (col_q),
        .rd_data (ent)
    );

    qcx_len_decode #(
        .COLS   (COLS),
        .MIN_Z  (MIN_Z),
        .MAX_Z  (REF_Z),
        .STEP_Z (STEP_Z),
        .LEN_W  (LEN_W),
        .Z_W    (Z_W)
    ) u_len (
        .len (cfg_len),
        .ok  (len_ok),
        .z   (z_new)
    );

    qcx_shift_scale #(
        .REF_Z (REF_Z),
        .MIN_Z (MIN_Z),
        .SH_W  (SH_W),
        .Z_W   (Z_W)
    ) u_scale (
        .base_val (ent[SH_W-1:0]),
        .z        (z_q),
        .use_mod  (mod_q),
        .shift    (scaled)
    );

    // Decode the walk conditions for this cycle.
    always_comb begin
        ent_empty   = ent[ENT_W-1];
        rows_ok     = (cfg_rows != '0) && (cfg_rows <= ROW_W'(MAX_ROWS));
        start_ok    = len_ok && rows_ok;
        slot_free   = !dv_q || desc_ready;
        at_last_col = (col_q == COL_W'(LAST_COL));
        at_last_row = (row_q == last_row_q);
    end

    // Walk state machine and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= WK_IDLE;
            row_q      <= '0;
            col_q      <= '0;
            last_row_q <= '0;
            z_q        <= Z_W'(REF_Z);
            mod_q      <= 1'b0;
        end else begin
            unique case (st_q)
                WK_IDLE: begin
                    if (start && start_ok) begin
                        z_q        <= z_new;
                        mod_q      <= cfg_modulo;
                        last_row_q <= cfg_rows - 1'b1;
                        row_q      <= '0;
                        col_q      <= '0;
                        st_q       <= WK_WALK;
                    end
                end
                WK_WALK: begin
                    if (slot_free) begin
                        if (at_last_col) begin
                            col_q <= '0;
                            if (at_last_row) begin
                                st_q <= WK_FLUSH;
                            end else begin
                                row_q <= row_q + 1'b1;
                            end
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end
                end
                WK_FLUSH: begin
                    if (slot_free) begin
                        st_q <= WK_IDLE;
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    // Output descriptor register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q   <= 1'b0;
            drow_q <= '0;
            dcol_q <= '0;
            dsh_q  <= '0;
        end else if (slot_free) begin
            dv_q <= 1'b0;
            if (st_q == WK_WALK && !ent_empty) begin
                dv_q   <= 1'b1;
                drow_q <= row_q;
                dcol_q <= col_q;
                dsh_q  <= scaled;
            end
        end
    end

    // End-of-walk pulse and rejected-start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (st_q == WK_FLUSH) && slot_free;
            if (st_q == WK_IDLE && start) begin
                err_q <= !start_ok;
            end
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        desc_valid = dv_q;
        desc_row   = drow_q;
        desc_col   = dcol_q;
        desc_shift = dsh_q;
        done       = done_q;
        len_err    = err_q;
    end
endmodule

// File: rtl/qcx_walker_chk.sv
// Module: protocol checker for qc_shift_walker, attached by bind.
// Does: checks stream hold, ranges, the done pulse shape and error silence.
// Assumes: default parameters of the package.
module qcx_walker_chk
    import qcx_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                desc_valid,
    input logic                desc_ready,
    input logic [QX_ROW_W-1:0] desc_row,
    input logic [QX_COL_W-1:0] desc_col,
    input logic [QX_SH_W-1:0]  desc_shift,
    input logic                done,
    input logic                len_err
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_row) && $stable(desc_col) && $stable(desc_shift)); // R8

    AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> desc_shift < QX_SH_W'(QX_REF_Z)); // R5

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_row < QX_ROW_W'(QX_MAX_ROWS)) && (desc_col < QX_COL_W'(QX_COLS))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_NO_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !desc_valid); // R9

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !desc_valid && !done); // R2
endmodule

bind qc_shift_walker qcx_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_row   (desc_row),
    .desc_col   (desc_col),
    .desc_shift (desc_shift),
    .done       (done),
    .len_err    (len_err)
);

// File: tb/qc_shift_walker_tb.sv
// Bench for qc_shift_walker: directed corner cases plus seeded random tables.
module qc_shift_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_row = '0;
    logic [4:0]  wr_col = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  cfg_rows = '0;
    logic [11:0] cfg_len = '0;
    logic        cfg_modulo = 1'b0;
    logic        start = 1'b0;
    logic        desc_ready = 1'b0;
    logic        desc_valid;
    logic [3:0]  desc_row;
    logic [4:0]  desc_col;
    logic [6:0]  desc_shift;
    logic        done;
    logic        len_err;

    int checks = 0;
    int failures = 0;

    logic [7:0] bm [12][24];
    int exp_r[$];
    int exp_c[$];
    int exp_s[$];
    int exp_p[$];

    always #10 clk = ~clk;

    qc_shift_walker u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .cfg_rows(cfg_rows), .cfg_len(cfg_len), .cfg_modulo(cfg_modulo),
        .start(start), .desc_ready(desc_ready), .desc_valid(desc_valid), .desc_row(desc_row),
        .desc_col(desc_col), .desc_shift(desc_shift), .done(done), .len_err(len_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int exp_shift(input int p, input int z, input bit m);
        if (p == 0) return 0;
        if (m) return p % z;
        return (p * z) / 96;
    endfunction

    task automatic wr(input int r, input int c, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 4'(r); wr_col = 5'(c); wr_data = 8'(d);
        bm[r][c] = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill_random();
        for (int r = 0; r < 12; r++) begin
            for (int c = 0; c < 24; c++) begin
                int k;
                k = $urandom % 100;
                if (k < 40) wr(r, c, 8'hFF);
                else if (k < 50) wr(r, c, 0);
                else wr(r, c, 1 + ($urandom % 95));
            end
        end
    endtask

    task automatic run_walk(input int rows, input int len, input bit mode, input int pct, input bit disturb);
        int z;
        int n;
        int dones;
        int cyc;
        bit hold;
        logic [3:0] h_r;
        logic [4:0] h_c;
        logic [6:0] h_s;
        z = len / 24;
        exp_r.delete(); exp_c.delete(); exp_s.delete(); exp_p.delete();
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < 24; c++) begin
                if (!bm[r][c][7]) begin
                    exp_r.push_back(r); exp_c.push_back(c);
                    exp_p.push_back(int'(bm[r][c]));
                    exp_s.push_back(exp_shift(int'(bm[r][c]), z, mode));
                end
            end
        end
        @(negedge clk);
        cfg_rows = 4'(rows); cfg_len = 12'(len); cfg_modulo = mode; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; dones = 0; cyc = 0; hold = 1'b0; h_r = '0; h_c = '0; h_s = '0;
        while (cyc < 5000 && dones == 0) begin
            if (hold) begin
                chk(desc_valid && desc_row == h_r && desc_col == h_c && desc_shift == h_s,
                    "R8 held descriptor changed", int'(desc_shift), int'(h_s));
            end
            if (done) begin
                dones++;
                chk(!desc_valid, "R9 valid during done", int'(desc_valid), 0);
            end
            start = 1'b0; wr_en = 1'b0;
            if (disturb && cyc == 3) begin
                start = 1'b1; cfg_len = 12'd100; cfg_modulo = ~mode; cfg_rows = 4'd0;
                wr_en = 1'b1; wr_row = 4'd0; wr_col = 5'd0; wr_data = 8'd5;
            end
            desc_ready = (($urandom % 100) < pct);
            if (desc_valid && desc_ready) begin
                if (n < exp_r.size()) begin
                    chk(int'(desc_row) == exp_r[n] && int'(desc_col) == exp_c[n], "R7 order",
                        int'(desc_row) * 100 + int'(desc_col), exp_r[n] * 100 + exp_c[n]);
                    chk(int'(desc_shift) == exp_s[n],
                        exp_p[n] == 0 ? "R4 identity shift" : (mode ? "R6 modulo shift" : "R5 scaled shift"),
                        int'(desc_shift), exp_s[n]);
                end else begin
                    chk(1'b0, "R3 extra descriptor", n, exp_r.size());
                end
                n++;
            end
            hold = desc_valid && !desc_ready;
            h_r = desc_row; h_c = desc_col; h_s = desc_shift;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; wr_en = 1'b0; desc_ready = 1'b0;
        chk(n == exp_r.size(), "R3 descriptor count", n, exp_r.size());
        chk(dones == 1, "R1 walk finished with done", dones, 1);
        chk(!len_err, disturb ? "R10 busy start ignored" : "R1 accepted length", int'(len_err), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!done && !desc_valid, "R9 quiet after done", int'(done) + int'(desc_valid), 0);
        end
    endtask

    task automatic run_bad(input int rows, input int len);
        int seen;
        @(negedge clk);
        cfg_rows = 4'(rows); cfg_len = 12'(len); start = 1'b1; desc_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            if (desc_valid || done) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R2 output after rejected start", seen, 0);
        chk(len_err, "R2 error flag", int'(len_err), 1);
        desc_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        for (int r = 0; r < 12; r++) for (int c = 0; c < 24; c++) bm[r][c] = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!desc_valid && !done && !len_err, "R11 reset outputs",
            int'(desc_valid) + int'(done) + int'(len_err), 0);
        // R11: table starts empty, so a full walk yields nothing.
        run_walk(12, 2304, 1'b0, 100, 1'b0);

        // Directed row: identity, extremes, empty encodings.
        wr(0, 0, 0);  wr(0, 1, 95); wr(0, 2, 8'hFF); wr(0, 3, 1);
        wr(0, 4, 48); wr(0, 5, 8'h80); wr(0, 23, 94);
        wr(1, 7, 33);
        run_walk(1, 576, 1'b0, 100, 1'b0);
        run_walk(1, 576, 1'b1, 100, 1'b0);
        run_walk(2, 2304, 1'b0, 50, 1'b0);
        run_walk(2, 2304, 1'b1, 50, 1'b0);
        run_walk(2, 1248, 1'b1, 40, 1'b0);

        // Rejected configurations, then recovery.
        run_bad(4, 600);
        run_bad(4, 2400);
        run_bad(4, 480);
        run_bad(4, 0);
        run_bad(0, 1152);
        run_bad(13, 1152);
        run_walk(2, 1152, 1'b0, 100, 1'b0);

        // Busy start and write must leave no trace.
        wr(0, 0, 7);
        run_walk(3, 960, 1'b0, 60, 1'b1);
        run_walk(3, 960, 1'b0, 100, 1'b0);

        // Random tables over the rate row counts.
        for (int k = 0; k < 10; k++) begin
            int rsel;
            int rows;
            fill_random();
            rsel = $urandom % 4;
            rows = (rsel == 0) ? 12 : (rsel == 1) ? 8 : (rsel == 2) ? 6 : 4;
            run_walk(rows, 576 + 96 * ($urandom % 19), 1'(($urandom % 2)),
                     30 + ($urandom % 71), (k % 3) == 0);
            run_walk(rows, 576 + 96 * ($urandom % 19), 1'(($urandom % 2)), 100, 1'b0);
        end

        // Every supported length in both modes.
        for (int li = 0; li < 19; li++) begin
            run_walk(4, 576 + 96 * li, 1'b0, 100, 1'b0);
            run_walk(4, 576 + 96 * li, 1'b1, 100, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule